// File: doc/BRIEF.md
# Issue-Order Result Merger

This block sits after four parallel processing units that receive work one after another. Each time the dispatcher accepts a work item, the block names the unit that must take it, cycling through the units in fixed rotation, and records that unit's index in an issue-order queue. The units finish at their own pace and hand their fixed-width vertex records back on four separate valid/ready ports. Each port fills a small FIFO of its own.

A single valid/ready output stream carries the records onward to the shared bus toward rasterization. The stream always follows issue order. The unit named at the head of the issue-order queue is the only one allowed to release a record. A record from any other unit waits, however early it arrives. The total buffer size is a parameter; the production target is 65,536 records, and smaller values are used in simulation.

Top module: `mrg_inorder_merge`

## Requirements
- R1: After reset, out_valid is 0, issue_ready is 1, every bit of res_ready is 1 and issue_unit is 0.
- R2: issue_unit steps through 0, 1, 2, 3, 0 and so on, by one for each accepted issue (issue_valid and issue_ready both high at a clock edge), and keeps its value in any other cycle.
- R3: Records leave on out_data in the order their work was issued, whatever order the units return them in.
- R4: out_valid stays low while the unit at the head of issue order has returned nothing, even when other units hold records.
- R5: While out_valid is high and out_ready is low, out_valid stays high and out_data keeps its value in the next cycle.
- R6: res_ready for a unit goes low once that unit's FIFO holds TOTAL_ENTRIES/4 records. A record offered while it is low is not stored and never appears on the output.
- R7: issue_ready goes low once ORDER_DEPTH issues are outstanding. An issue offered while it is low is not recorded and does not advance issue_unit.
- R8: Reset applied in the middle of traffic empties every queue and restarts rotation at unit 0. Traffic afterwards merges correctly from a clean state.
- R9: A record accepted from the head unit at a clock edge shows up on out_data with out_valid high straight after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Dispatcher offers one work item |
| issue_ready | output | 1 | Issue-order queue has room |
| issue_unit | output | 2 | Unit that takes the next accepted work item |
| res_valid | input | 4 | Per-unit result offered (bit u = unit u) |
| res_ready | output | 4 | Per-unit FIFO has room |
| res_data | input | 4*DATA_W | Per-unit records, unit u in bits [u*DATA_W +: DATA_W] |
| out_valid | output | 1 | Merged record available |
| out_ready | input | 1 | Downstream accepts the record |
| out_data | output | DATA_W | Merged record in issue order |

## Verification
The bench builds the block with DATA_W = 16, TOTAL_ENTRIES = 16 and ORDER_DEPTH = 16. That gives each unit FIFO four slots and the issue-order queue sixteen. With sixteen outstanding issues, every unit has four items pending. This fills the issue-order queue and lets a single unit fill its own FIFO in one run, so both backpressure limits and a refused extra result can be exercised. Records are tagged with their issue number, so any reordering, loss or duplication shows up directly on the output.

// File: rtl/mrg_pkg.sv
package mrg_pkg;
   localparam int unsigned NUM_SRC   = 4;
   localparam int unsigned SRC_IDX_W = 2;
   typedef logic [SRC_IDX_W-1:0] src_idx_t;
endpackage

// File: rtl/mrg_fifo.sv
module mrg_fifo #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             full,
   output logic             empty
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("mrg_fifo: DEPTH must be a power of two, at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("mrg_fifo: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic [CW-1:0]    cnt;

   assign full  = (cnt == CW'(DEPTH));
   assign empty = (cnt == '0);
   assign dout  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         if (push && !pop)      cnt <= cnt + 1'b1;
         else if (pop && !push) cnt <= cnt - 1'b1;
      end
   end

   // R6: occupancy rises by one on a lone write
   a_r6_count_up: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop) |=> (cnt == CW'($past(cnt) + 1'b1)));
   // R3: occupancy falls by one on a lone read
   a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push) |=> (cnt == CW'($past(cnt) - 1'b1)));
   // R3: nothing is read from an empty queue
   a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/mrg_dispatch.sv
module mrg_dispatch
   import mrg_pkg::*;
#(
   parameter int unsigned ORDER_DEPTH = 16
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     issue_valid,
   output logic     issue_ready,
   output src_idx_t issue_unit,
   input  logic     head_pop,
   output src_idx_t head_unit,
   output logic     head_valid
);
   generate
      if (ORDER_DEPTH < NUM_SRC) begin : g_bad_order
         $error("mrg_dispatch: ORDER_DEPTH must cover one round of units");
      end
   endgenerate

   logic     oq_full, oq_empty, issue_fire;
   src_idx_t rr_ptr;

   assign issue_ready = !oq_full;
   assign issue_fire  = issue_valid && issue_ready;
   assign issue_unit  = rr_ptr;
   assign head_valid  = !oq_empty;

   always_ff @(posedge clk) begin
      if (!rst_n)          rr_ptr <= '0;
      else if (issue_fire) rr_ptr <= rr_ptr + 1'b1;
   end

   mrg_fifo #(.WIDTH(SRC_IDX_W), .DEPTH(ORDER_DEPTH)) u_order_q (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (issue_fire),
      .din   (rr_ptr),
      .pop   (head_pop),
      .dout  (head_unit),
      .full  (oq_full),
      .empty (oq_empty)
   );

   // R2: rotation advances by one per accepted issue
   a_r2_rr_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && issue_ready) |=> (issue_unit == src_idx_t'($past(issue_unit) + 1'b1)));
   // R7: a refused or absent issue leaves rotation alone
   a_r7_rr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(issue_valid && issue_ready) |=> $stable(issue_unit));
endmodule

// File: rtl/mrg_inorder_merge.sv
module mrg_inorder_merge
   import mrg_pkg::*;
#(
   parameter int unsigned DATA_W        = 64,
   parameter int unsigned TOTAL_ENTRIES = 256,
   parameter int unsigned ORDER_DEPTH   = TOTAL_ENTRIES
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       issue_valid,
   output logic                       issue_ready,
   output logic [1:0]                 issue_unit,
   input  logic [3:0]                 res_valid,
   output logic [3:0]                 res_ready,
   input  logic [4*DATA_W-1:0]        res_data,
   output logic                       out_valid,
   input  logic                       out_ready,
   output logic [DATA_W-1:0]          out_data
);
   localparam int unsigned SRC_DEPTH = TOTAL_ENTRIES / NUM_SRC;

   generate
      if (TOTAL_ENTRIES % NUM_SRC != 0) begin : g_bad_total
         $error("mrg_inorder_merge: TOTAL_ENTRIES must split evenly over units");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("mrg_inorder_merge: DATA_W must be positive");
      end
   endgenerate

   src_idx_t    head_unit;
   logic        head_valid, out_fire;
   logic [DATA_W-1:0] src_head [NUM_SRC];
   logic [NUM_SRC-1:0] src_empty, src_full;

   assign out_valid = head_valid && !src_empty[head_unit];
   assign out_data  = src_head[head_unit];
   assign out_fire  = out_valid && out_ready;

   mrg_dispatch #(.ORDER_DEPTH(ORDER_DEPTH)) u_dispatch (
      .clk         (clk),
      .rst_n       (rst_n),
      .issue_valid (issue_valid),
      .issue_ready (issue_ready),
      .issue_unit  (issue_unit),
      .head_pop    (out_fire),
      .head_unit   (head_unit),
      .head_valid  (head_valid)
   );

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      logic src_push, src_pop;
      assign res_ready[g] = !src_full[g];
      assign src_push     = res_valid[g] && !src_full[g];
      assign src_pop      = out_fire && (head_unit == src_idx_t'(g));

      mrg_fifo #(.WIDTH(DATA_W), .DEPTH(SRC_DEPTH)) u_src_q (
         .clk   (clk),
         .rst_n (rst_n),
         .push  (src_push),
         .din   (res_data[g*DATA_W +: DATA_W]),
         .pop   (src_pop),
         .dout  (src_head[g]),
         .full  (src_full[g]),
         .empty (src_empty[g])
      );
   end

   // R5: a stalled output keeps valid and data
   a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: tb/mrg_inorder_merge_bench.sv
module mrg_inorder_merge_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 16;
   localparam logic [DW-1:0] BASE = 16'hA000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic issue_valid = 1'b0;
   logic issue_ready;
   logic [1:0] issue_unit;
   logic [3:0] res_valid = '0;
   logic [3:0] res_ready;
   logic [4*DW-1:0] res_data = '0;
   logic out_valid;
   logic out_ready = 1'b0;
   logic [DW-1:0] out_data;

   int total = 0;
   int bad = 0;
   int exp_unit = 0;
   int exp_out = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mrg_inorder_merge #(.DATA_W(DW), .TOTAL_ENTRIES(16), .ORDER_DEPTH(16)) u_mrg_inorder_merge (
      .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
      .issue_unit(issue_unit), .res_valid(res_valid), .res_ready(res_ready),
      .res_data(res_data), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
   );

   task automatic check(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      issue_valid = 1'b0; res_valid = '0; out_ready = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      exp_unit = 0;
      exp_out = 0;
   endtask

   task automatic issue_n(int n);
      for (int i = 0; i < n; i++) begin
         check("R2 issue_unit", int'(issue_unit), exp_unit);
         check("R7 issue_ready", int'(issue_ready), 1);
         issue_valid = 1'b1;
         @(negedge clk);
         exp_unit = (exp_unit + 1) % 4;
      end
      issue_valid = 1'b0;
   endtask

   task automatic send(int u, int seq);
      check("R6 res_ready", int'(res_ready[u]), 1);
      res_valid[u] = 1'b1;
      res_data[u*DW +: DW] = BASE + DW'(seq);
      @(negedge clk);
      res_valid[u] = 1'b0;
   endtask

   task automatic drain(int n);
      out_ready = 1'b1;
      for (int i = 0; i < n; i++) begin
         check("R3 out_valid", int'(out_valid), 1);
         check("R3 out_data", int'(out_data), int'(BASE + DW'(exp_out)));
         @(negedge clk);
         exp_out++;
      end
      out_ready = 1'b0;
   endtask

   task automatic t_reset_state();
      do_reset();
      check("R1 out_valid", int'(out_valid), 0);
      check("R1 issue_ready", int'(issue_ready), 1);
      check("R1 res_ready", int'(res_ready), 4'hF);
      check("R1 issue_unit", int'(issue_unit), 0);
   endtask

   task automatic t_reverse_return();
      issue_n(4);
      send(3, 3); send(2, 2); send(1, 1);
      check("R4 head missing", int'(out_valid), 0);
      send(0, 0);
      check("R9 passthrough valid", int'(out_valid), 1);
      check("R9 passthrough data", int'(out_data), int'(BASE));
      drain(4);
      check("R3 empty after drain", int'(out_valid), 0);
   endtask

   task automatic t_stall();
      issue_n(4);
      send(0, 4);
      out_ready = 1'b0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check("R5 valid held", int'(out_valid), 1);
         check("R5 data held", int'(out_data), int'(BASE + 16'd4));
      end
      send(1, 5);
      check("R5 data held after other arrival", int'(out_data), int'(BASE + 16'd4));
      send(2, 6); send(3, 7);
      drain(4);
   endtask

   task automatic t_backpressure();
      issue_n(16);
      check("R7 queue full", int'(issue_ready), 0);
      issue_valid = 1'b1;
      @(negedge clk);
      issue_valid = 1'b0;
      check("R7 refused issue keeps unit", int'(issue_unit), 0);
      for (int k = 0; k < 4; k++) send(1, 9 + 4*k);
      check("R6 unit full", int'(res_ready[1]), 0);
      res_valid[1] = 1'b1;
      res_data[DW +: DW] = 16'hDEAD;
      @(negedge clk);
      res_valid[1] = 1'b0;
      for (int k = 0; k < 4; k++) send(0, 8 + 4*k);
      for (int k = 0; k < 4; k++) send(2, 10 + 4*k);
      for (int k = 0; k < 4; k++) send(3, 11 + 4*k);
      drain(16);
      check("R6 refused record absent", int'(out_valid), 0);
      check("R7 ready after drain", int'(issue_ready), 1);
   endtask

   task automatic t_midstream_reset();
      issue_n(3);
      send(1, 1);
      send(0, 0);
      do_reset();
      check("R8 out_valid", int'(out_valid), 0);
      check("R8 issue_unit", int'(issue_unit), 0);
      check("R8 res_ready", int'(res_ready), 4'hF);
      check("R8 issue_ready", int'(issue_ready), 1);
      issue_n(2);
      send(1, 1);
      check("R8 stale record gone", int'(out_valid), 0);
      send(0, 0);
      drain(2);
      check("R8 empty after rerun", int'(out_valid), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_reset_state();
      t_reverse_return();
      t_stall();
      t_backpressure();
      t_midstream_reset();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule